// File: doc/BRIEF.md
# Multi-Lane Channel Lock Controller

This block manages word and lane synchronisation for a four-lane serial receiver. It takes one received character per lane per clock cycle. Each lane's decoder supplies four flags: comma, valid data, decode error and clock-recovery loss of lock. Each lane has its own synchronisation state machine. The lane hunts for a comma, counts a run of commas that a single bit error cannot fake, and then waits for the first data character. In lock mode the lanes are linked. A shared deskew monitor checks that every lane's first data character arrives within a short window. When it does, the monitor asks the external deskew aligner to capture the lane offsets. The lanes enter the locked state together once the aligner acknowledges.

Each lane reports its state as a three-bit code on separate error, frame and comma status lines. The locked state is left when the error behaviour degrades: a run of decode errors, or an error density above one half over a block of characters. Software and board logic can force every lane back to hunting by pulling the resync request low, by a falling edge on the lock-mode enable, or by reset. With lock mode off, the linkage is cut and each lane locks on its own.

Top module: `lane_lock_ctrl`

## Requirements
- R1: During and after reset, and with no comma received, every lane is in the hunting state and reports err=1, eof=0, kflag=1; `align_capture` is 0.
- R2: A hunting lane that sees a comma (`rx_comma`=1) moves to acquiring and reports err=0, eof=1, kflag=1 from the following cycle.
- R3: The fourth consecutive comma moves a lane to the re-sync state, which keeps reporting 0-1-1 until a data character (`rx_data`=1 with `rx_comma`=0) arrives; from the next cycle it reports 1-1-1.
- R4: While acquiring, any character that is not a comma restarts the comma count, so runs of three commas split by a gap never reach re-sync.
- R5: In lock mode, `align_capture` is high for exactly one cycle once all lanes are in re-sync and have seen data. The last lane's first data character must come no more than four characters after the first lane's. If it comes later, all lanes return to hunting on the character five positions after the first.
- R6: With lock mode on, lanes enter the locked state only on a cycle where `align_ok` is high after a capture. All lanes then report err=0, eof=1, kflag=0 together from the next cycle.
- R7: A locked lane returns to hunting on its fourth consecutive decode error; three in a row followed by a clean character leave it locked.
- R8: In the locked state, characters are counted in free-running blocks of 16 starting with the first locked character. A block with more than 8 decode errors sends the lane to hunting on its last character. Exactly 8 errors does not, and the tally restarts at every block boundary.
- R9: `rx_los` on a lane sends that lane to hunting on the next cycle whatever its state.
- R10: A low `resync_n`, or a falling edge on `lock_en`, sends every lane to hunting on the next cycle.
- R11: In lock mode, when any locked lane loses lock, every lane returns to hunting in the same cycle.
- R12: With `lock_en` low, each lane runs alone. A lane in re-sync that has seen data locks on the following cycle, other lanes are unaffected, and `align_capture` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Lock mode: links the lanes when high; a falling edge restarts all lanes |
| resync_n | input | 1 | Active-low request forcing all lanes to hunting |
| rx_comma | input | NLANES | Per-lane comma character seen this cycle |
| rx_data | input | NLANES | Per-lane valid data character seen this cycle |
| rx_dec_err | input | NLANES | Per-lane decode error this cycle |
| rx_los | input | NLANES | Per-lane clock-recovery loss of lock |
| align_ok | input | 1 | Deskew aligner acknowledges a capture |
| align_capture | output | 1 | Request to the aligner to capture lane offsets |
| stat_err | output | NLANES | Per-lane status, error bit |
| stat_eof | output | NLANES | Per-lane status, frame bit |
| stat_kflag | output | NLANES | Per-lane status, comma bit |

## Verification
Every state is visible as a status code one cycle after the character that caused it. A lane stuck in the wrong state therefore shows up at the ports on the next character. Hidden counters are harder to see. A comma count that is not restarted shows only when a later data character produces 1-1-1 where 0-1-1 was due. An error tally that is not cleared, or a block boundary one position off, shows only at the last character of a 16-character block. An off-by-one deskew window shows only when the last lane's data comes exactly four or five characters after the first.

// File: rtl/lane_lock_pkg.sv
package lane_lock_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_ACQ    = 2'd1,
    ST_RESYNC = 2'd2,
    ST_LOCKED = 2'd3
  } lane_state_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GATHER = 2'd1,
    PH_ACK    = 2'd2
  } link_phase_e;

  typedef struct packed {
    logic err;
    logic eof;
    logic kflag;
  } lane_stat_t;

  // Status code seen at the ports for a lane state.
  function automatic lane_stat_t status_code(input lane_state_e st, input logic seen);
    lane_stat_t s;
    case (st)
      ST_HUNT:   s = lane_stat_t'(3'b101);
      ST_ACQ:    s = lane_stat_t'(3'b011);
      ST_RESYNC: s = seen ? lane_stat_t'(3'b111) : lane_stat_t'(3'b011);
      ST_LOCKED: s = lane_stat_t'(3'b010);
      default:   s = lane_stat_t'(3'b101);
    endcase
    return s;
  endfunction

  // True when this error completes a run of 'limit' consecutive errors.
  function automatic logic run_trip(input int unsigned run, input logic hit,
                                    input int unsigned limit);
    return hit && ((run + 1) >= limit);
  endfunction

  // True when the block tally including this character exceeds one half.
  function automatic logic rate_trip(input int unsigned tally, input logic hit,
                                     input int unsigned blk_len);
    int unsigned total;
    total = tally + (hit ? 32'd1 : 32'd0);
    return (total * 2) > blk_len;
  endfunction

endpackage

// File: rtl/lane_err_mon.sv
module lane_err_mon #(
  parameter int RUN_LIMIT = 4,
  parameter int BLOCK_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic dec_err,
  output logic trip
);
  import lane_lock_pkg::*;

  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam int BW = $clog2(BLOCK_LEN);
  localparam int TW = $clog2(BLOCK_LEN + 1);

  logic [RW-1:0] run_q;
  logic [BW-1:0] blk_q;
  logic [TW-1:0] tally_q;
  logic          blk_last;
  logic          run_hit;
  logic          rate_hit;

  assign blk_last = active && (32'(blk_q) == BLOCK_LEN - 1);
  assign run_hit  = active && run_trip(32'(run_q), dec_err, RUN_LIMIT);
  assign rate_hit = blk_last && rate_trip(32'(tally_q), dec_err, BLOCK_LEN);
  assign trip     = run_hit || rate_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      blk_q   <= '0;
      tally_q <= '0;
    end else if (!active) begin
      run_q   <= '0;
      blk_q   <= '0;
      tally_q <= '0;
    end else begin
      if (!dec_err)
        run_q <= '0;
      else if (32'(run_q) < RUN_LIMIT)
        run_q <= run_q + 1'b1;
      blk_q   <= blk_last ? '0 : blk_q + 1'b1;
      tally_q <= blk_last ? '0 : tally_q + TW'(dec_err);
    end
  end

endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm #(
  parameter int COMMA_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_comma,
  input  logic is_data,
  input  logic cdr_los,
  input  logic err_exit,
  input  logic force_hunt,
  input  logic link_mode,
  input  logic link_go,
  input  logic link_fail,
  output lane_lock_pkg::lane_state_e state,
  output logic seen,
  output logic lose_lock
);
  import lane_lock_pkg::*;

  localparam int CW = $clog2(COMMA_RUN + 1);

  lane_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (force_hunt || link_fail || cdr_los) begin
      st_d   = ST_HUNT;
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (is_comma) begin
            st_d  = ST_ACQ;
            cnt_d = CW'(1);
          end
        end
        ST_ACQ: begin
          if (is_comma) begin
            if ((32'(cnt_q) + 1) >= COMMA_RUN) begin
              st_d  = ST_RESYNC;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        ST_RESYNC: begin
          if (is_data) seen_d = 1'b1;
          if (link_mode ? link_go : seen_q) begin
            st_d   = ST_LOCKED;
            seen_d = 1'b0;
          end
        end
        ST_LOCKED: begin
          if (err_exit) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign state     = st_q;
  assign seen      = seen_q;
  assign lose_lock = (st_q == ST_LOCKED) && (cdr_los || err_exit);

endmodule

// File: rtl/lane_deskew_link.sv
module lane_deskew_link #(
  parameter int NLANES = 4,
  parameter int WINDOW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_mode,
  input  logic              abort,
  input  logic [NLANES-1:0] in_resync,
  input  logic [NLANES-1:0] seen,
  input  logic              align_ok,
  output logic              capture,
  output logic              go,
  output logic              fail
);
  import lane_lock_pkg::*;

  localparam int WW = $clog2(WINDOW + 1);

  link_phase_e   ph_q;
  logic [WW-1:0] cnt_q;
  logic          all_seen, any_seen, all_resync;
  logic          win_fail, ack_lost;

  assign all_seen   = &seen;
  assign any_seen   = |seen;
  assign all_resync = &in_resync;

  assign capture  = link_mode && (ph_q != PH_ACK) && all_seen;
  assign go       = link_mode && (ph_q == PH_ACK) && align_ok && all_resync;
  assign win_fail = link_mode && (ph_q == PH_GATHER) && !all_seen
                    && (32'(cnt_q) == WINDOW - 1);
  assign ack_lost = link_mode && (ph_q == PH_ACK) && !all_resync;
  assign fail     = win_fail || ack_lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (!link_mode || abort || fail || go) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (capture) begin
            ph_q <= PH_ACK;
          end else if (any_seen) begin
            ph_q  <= PH_GATHER;
            cnt_q <= WW'(1);
          end
        end
        PH_GATHER: begin
          if (capture) ph_q <= PH_ACK;
          else         cnt_q <= cnt_q + 1'b1;
        end
        PH_ACK:  ph_q <= PH_ACK;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_lock_ctrl.sv
module lane_lock_ctrl #(
  parameter int NLANES    = 4,
  parameter int COMMA_RUN = 4,
  parameter int WINDOW    = 5,
  parameter int RUN_LIMIT = 4,
  parameter int BLOCK_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_en,
  input  logic              resync_n,
  input  logic [NLANES-1:0] rx_comma,
  input  logic [NLANES-1:0] rx_data,
  input  logic [NLANES-1:0] rx_dec_err,
  input  logic [NLANES-1:0] rx_los,
  input  logic              align_ok,
  output logic              align_capture,
  output logic [NLANES-1:0] stat_err,
  output logic [NLANES-1:0] stat_eof,
  output logic [NLANES-1:0] stat_kflag
);
  import lane_lock_pkg::*;

  logic              lock_q;
  logic              force_hunt;
  logic              link_go, link_fail_dl, collapse, lane_fail;
  lane_state_e       lane_st [NLANES];
  logic [NLANES-1:0] lane_seen, lane_lose, mon_trip;
  logic [NLANES-1:0] lane_hunt, lane_resync, lane_locked;
  logic [NLANES-1:0] is_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_en;
  end

  assign force_hunt = !resync_n || (lock_q && !lock_en);
  assign is_data    = rx_data & ~rx_comma;
  assign collapse   = lock_en && (|lane_lose);
  assign lane_fail  = link_fail_dl || collapse;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    lane_err_mon #(
      .RUN_LIMIT(RUN_LIMIT),
      .BLOCK_LEN(BLOCK_LEN)
    ) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (lane_locked[g]),
      .dec_err(rx_dec_err[g]),
      .trip   (mon_trip[g])
    );

    lane_sync_fsm #(
      .COMMA_RUN(COMMA_RUN)
    ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_comma  (rx_comma[g]),
      .is_data   (is_data[g]),
      .cdr_los   (rx_los[g]),
      .err_exit  (mon_trip[g]),
      .force_hunt(force_hunt),
      .link_mode (lock_en),
      .link_go   (link_go),
      .link_fail (lane_fail),
      .state     (lane_st[g]),
      .seen      (lane_seen[g]),
      .lose_lock (lane_lose[g])
    );

    assign lane_hunt[g]   = (lane_st[g] == ST_HUNT);
    assign lane_resync[g] = (lane_st[g] == ST_RESYNC);
    assign lane_locked[g] = (lane_st[g] == ST_LOCKED);
    assign {stat_err[g], stat_eof[g], stat_kflag[g]} = status_code(lane_st[g], lane_seen[g]);
  end

  lane_deskew_link #(
    .NLANES(NLANES),
    .WINDOW(WINDOW)
  ) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_mode(lock_en),
    .abort    (force_hunt),
    .in_resync(lane_resync),
    .seen     (lane_seen),
    .align_ok (align_ok),
    .capture  (align_capture),
    .go       (link_go),
    .fail     (link_fail_dl)
  );

endmodule

// File: rtl/lane_lock_chk.sv
module lane_lock_chk #(
  parameter int NLANES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_en,
  input logic              resync_n,
  input logic              align_ok,
  input logic              align_capture,
  input logic [NLANES-1:0] rx_los,
  input logic [NLANES-1:0] stat_err,
  input logic [NLANES-1:0] stat_eof,
  input logic [NLANES-1:0] stat_kflag,
  input logic [NLANES-1:0] lane_hunt,
  input logic [NLANES-1:0] lane_locked,
  input logic [NLANES-1:0] mon_trip
);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    AST_LOS_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_los[i] |=> lane_hunt[i]) else $error("los did not force hunting"); // R9
    AST_LOCKED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      lane_locked[i] |-> (stat_err[i] == 1'b0 && stat_eof[i] == 1'b1 && stat_kflag[i] == 1'b0))
      else $error("locked lane code wrong"); // R6
    AST_TRIP_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      mon_trip[i] |=> lane_hunt[i]) else $error("error trip ignored"); // R7
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_eof[i] || (stat_err[i] && stat_kflag[i])) && (stat_err[i] || stat_eof[i]))
      else $error("illegal status code"); // R3
  end

  AST_RESYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_n |=> (&lane_hunt)) else $error("resync request ignored"); // R10
  AST_ENABLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_en) |=> (&lane_hunt)) else $error("lock enable fall ignored"); // R10
  AST_ACK_GATES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_en) && (|(lane_locked & ~$past(lane_locked)))) |-> $past(align_ok))
    else $error("lock without acknowledge"); // R6
  AST_CAPTURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    align_capture |-> ((&stat_err) && (&stat_eof) && (&stat_kflag)))
    else $error("capture while a lane lacks data"); // R5
  AST_CAPTURE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    align_capture |=> !align_capture) else $error("capture longer than a cycle"); // R5

endmodule

bind lane_lock_ctrl lane_lock_chk #(.NLANES(NLANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lock_en      (lock_en),
  .resync_n     (resync_n),
  .align_ok     (align_ok),
  .align_capture(align_capture),
  .rx_los       (rx_los),
  .stat_err     (stat_err),
  .stat_eof     (stat_eof),
  .stat_kflag   (stat_kflag),
  .lane_hunt    (lane_hunt),
  .lane_locked  (lane_locked),
  .mon_trip     (mon_trip)
);

// File: tb/lane_lock_ctrl_bench.sv
module lane_lock_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_en = 1'b1;
  logic       resync_n = 1'b1;
  logic [3:0] comma = '0, data = '0, derr = '0, los = '0;
  logic       align = 1'b0;
  logic       cap;
  logic [3:0] s_err, s_eof, s_kf;
  int         n_chk = 0;
  int         n_bad = 0;

  always #10 clk = ~clk;

  lane_lock_ctrl u_lane_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .resync_n(resync_n),
    .rx_comma(comma), .rx_data(data), .rx_dec_err(derr), .rx_los(los),
    .align_ok(align), .align_capture(cap),
    .stat_err(s_err), .stat_eof(s_eof), .stat_kflag(s_kf)
  );

  // {comma, data, align, exp err, exp eof, exp kflag, exp capture}
  localparam logic [21:0] VEC [12] = '{
    {4'b0000, 4'b0000, 1'b0, 4'b1111, 4'b0000, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b1111, 4'b0000, 1'b0, 4'b0000, 4'b1111, 4'b1111, 1'b0},
    {4'b0000, 4'b0011, 1'b0, 4'b0011, 4'b1111, 4'b1111, 1'b0},
    {4'b0000, 4'b0100, 1'b0, 4'b0111, 4'b1111, 4'b1111, 1'b0},
    {4'b0000, 4'b1000, 1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b1},
    {4'b0000, 4'b0000, 1'b0, 4'b1111, 4'b1111, 4'b1111, 1'b0},
    {4'b0000, 4'b0000, 1'b1, 4'b0000, 4'b1111, 4'b0000, 1'b0},
    {4'b0000, 4'b1111, 1'b0, 4'b0000, 4'b1111, 4'b0000, 1'b0}
  };

  function automatic string vec_req(input int i);
    if (i == 0) return "R1";
    if (i == 1) return "R2";
    if (i <= 5) return "R3";
    if (i <= 9) return "R5";
    return "R6";
  endfunction

  task automatic step(input logic [3:0] c, input logic [3:0] d, input logic [3:0] e,
                      input logic [3:0] l, input logic a);
    @(negedge clk);
    comma = c; data = d; derr = e; los = l; align = a;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input string req, input logic [3:0] ee, input logic [3:0] eo,
                           input logic [3:0] ek, input logic ec);
    n_chk++;
    if (s_err !== ee || s_eof !== eo || s_kf !== ek || cap !== ec) begin
      n_bad++;
      $display("FAIL %s: got err=%b eof=%b kflag=%b cap=%b, expected err=%b eof=%b kflag=%b cap=%b",
               req, s_err, s_eof, s_kf, cap, ee, eo, ek, ec);
    end
  endtask

  task automatic expect_hunt(input string req);
    expect_st(req, 4'b1111, 4'b0000, 4'b1111, 1'b0);
  endtask

  task automatic expect_lock(input string req);
    expect_st(req, 4'b0000, 4'b1111, 4'b0000, 1'b0);
  endtask

  task automatic acquire();
    repeat (4) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'hF, 4'h0, 4'h0, 1'b0);
    expect_st("R5", 4'b1111, 4'b1111, 4'b1111, 1'b1);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    expect_lock("R6");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: state during reset
    repeat (2) @(posedge clk);
    #1;
    expect_hunt("R1");
    @(negedge clk);
    rst_n = 1'b1;

    // Main vector table: linked acquisition with skewed data arrival
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][21:18], VEC[i][17:14], 4'h0, 4'h0, VEC[i][13]);
      expect_st(vec_req(i), VEC[i][12:9], VEC[i][8:5], VEC[i][4:1], VEC[i][0]);
    end

    // R7 and R11: three errors keep lock, four on one lane drop all lanes
    repeat (3) step(4'h0, 4'hF, 4'hF, 4'h0, 1'b0);
    step(4'h0, 4'hF, 4'h0, 4'h0, 1'b0);
    expect_lock("R7");
    repeat (3) step(4'h0, 4'hF, 4'b0001, 4'h0, 1'b0);
    expect_lock("R7");
    step(4'h0, 4'hF, 4'b0001, 4'h0, 1'b0);
    expect_hunt("R11");

    // R8: two blocks of exactly half errors, then one block above half
    acquire();
    for (int i = 0; i < 32; i++)
      step(4'h0, 4'hF, (i % 2 == 0) ? 4'hF : 4'h0, 4'h0, 1'b0);
    expect_lock("R8");
    for (int i = 0; i < 16; i++) begin
      step(4'h0, 4'hF, (i % 3 != 2) ? 4'hF : 4'h0, 4'h0, 1'b0);
      if (i == 14) expect_lock("R8");
      if (i == 15) expect_hunt("R8");
    end

    // R9: loss of clock recovery on one lane
    acquire();
    step(4'h0, 4'hF, 4'h0, 4'b0100, 1'b0);
    expect_hunt("R9");

    // R4: split comma runs never reach re-sync
    repeat (3) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    repeat (3) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'hF, 4'h0, 4'h0, 1'b0);
    expect_st("R4", 4'b0000, 4'b1111, 4'b1111, 1'b0);

    // R10: resync request low
    resync_n = 1'b0;
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_hunt("R10");
    resync_n = 1'b1;

    // R5: last lane's data four characters late still captures
    repeat (4) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'b0111, 4'h0, 4'h0, 1'b0);
    repeat (3) step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'b1000, 4'h0, 4'h0, 1'b0);
    expect_st("R5", 4'b1111, 4'b1111, 4'b1111, 1'b1);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    expect_lock("R6");

    // R10: falling lock enable; R12: independent lane with linkage cut
    lock_en = 1'b0;
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_hunt("R10");
    repeat (4) step(4'b0001, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_st("R12", 4'b1110, 4'b0001, 4'b1111, 1'b0);
    step(4'h0, 4'b0001, 4'h0, 4'h0, 1'b0);
    expect_st("R12", 4'b1111, 4'b0001, 4'b1111, 1'b0);
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_st("R12", 4'b1110, 4'b0001, 4'b1110, 1'b0);
    lock_en  = 1'b1;
    resync_n = 1'b0;
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    resync_n = 1'b1;
    expect_hunt("R10");

    // R5: last lane's data five characters late fails the window
    repeat (4) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    step(4'h0, 4'b0111, 4'h0, 4'h0, 1'b0);
    repeat (4) step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_st("R5", 4'b0111, 4'b1111, 4'b1111, 1'b0);
    step(4'h0, 4'b1000, 4'h0, 4'h0, 1'b0);
    expect_hunt("R5");

    // R1: reset in the middle of acquisition
    repeat (2) step(4'hF, 4'h0, 4'h0, 4'h0, 1'b0);
    rst_n = 1'b0;
    step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    expect_hunt("R1");
    @(negedge clk);
    rst_n = 1'b1;

    summary();
    $finish;
  end

endmodule